// File: doc/BRIEF.md
# CPU Low-Power Mode Sequencer

A per-core controller that takes a core from active execution into one of four low-power modes and back again. The core signals a wait-for-interrupt event. The sequencer then gates the core clock and runs the enter steps of the mode held in its mode register. It waits for an interrupt and then runs the exit steps. The four modes are standby, retention, standalone power collapse and full power collapse. The outputs to the core and its cluster are a clock gate, a retention-voltage request, a power switch enable, a core reset and a cache-standby request.

Cluster-wide steps depend on an all-cores-idle input. These are the cache-standby request in standby and the shutdown handshake in full power collapse. In full power collapse the block also runs a request/acknowledge exchange with a system resource manager. A settle count, given on an input, is timed after every supply or voltage change. A status output shows the current step. A sticky field keeps the last mode that ran to completion.

Top module: `cpu_lpm_seq`

## Requirements
- R1: After reset, clk_gate, ret_req, cache_stby_req, rm_req, core_rst and last_valid are 0, pwr_en is 1, state_o is 0 and mode_o is 0 (standby).
- R2: A rising edge of wfi seen while idle starts a run of the mode in mode_o, and clk_gate is high from the next clock edge until the run ends. state_o codes are: 0 idle, 1 retention entry, 2 power-down, 3 waiting for interrupt, 4 resource request, 5 resource release, 6 retention exit, 7 power-up, 8 cache check.
- R3: If irq_pending is high when the wfi edge is seen, no run starts. clk_gate, ret_req and pwr_en do not change, and mode_o keeps its value.
- R4: Mode codes are 0 standby, 1 retention, 2 standalone collapse and 3 full collapse. mode_wr loads mode_wdata only while idle; writes during a run are ignored. When a run completes, mode_o returns to 0, last_mode holds the mode that ran and last_valid is set.
- R5: In standby, cache_stby_req is high during the wait only while all_idle is high. On wake, the core is not resumed (clk_gate and core_rst stay high) while cache_stby_ack is high. This cache check applies to every mode.
- R6: Retention raises ret_req and keeps pwr_en high. On wake, ret_req drops first and the core resumes after the settle time.
- R7: The two collapse modes drop pwr_en and raise core_rst on the edge that sees the trigger. Each settle stage lasts settle_cycles+1 cycles, counted from the edge that starts it. The wait is reached settle_cycles+1 edges after the trigger edge. On the wake edge pwr_en rises. Clock ungating and reset release come settle_cycles+2 edges after the wake edge, provided the cache is out of standby (cache_stby_ack low).
- R8: Standalone collapse never raises rm_req, whatever the value of all_idle.
- R9: In full collapse with all_idle high during the wait, rm_req rises and stays high until rm_ack is seen. After wake, power is not restored while rm_ack is still high.
- R10: The wait step is left only through irq_pending; the block stays in state 3 for as long as no interrupt is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 2 | Mode to write |
| settle_cycles | input | CNT_W | Settle count after supply or voltage changes |
| wfi | input | 1 | Core wait-for-interrupt indication |
| irq_pending | input | 1 | Interrupt pending for this core |
| all_idle | input | 1 | All cores of the cluster are idle |
| cache_stby_ack | input | 1 | Cache hierarchy is in standby |
| rm_ack | input | 1 | Resource manager acknowledge |
| clk_gate | output | 1 | Core clock gate |
| ret_req | output | 1 | Retention voltage request |
| pwr_en | output | 1 | Core power switch enable |
| core_rst | output | 1 | Core reset (warm boot on release) |
| cache_stby_req | output | 1 | Cache standby request |
| rm_req | output | 1 | Shutdown request to resource manager |
| state_o | output | 4 | Current step code |
| mode_o | output | 2 | Mode register |
| last_mode | output | 2 | Last completed mode |
| last_valid | output | 1 | last_mode holds a completed mode |

## Verification
The bench builds the block with CNT_W=4 and sweeps settle counts 0 to 3 over every mode, with all_idle both low and high. This puts the zero-count corner and every settle stage length within a few cycles of each other, so the bench can count entry and exit latencies exactly. The small width also lets the handshake, cache-hold and skip cases be driven step by step at the ports.

// File: rtl/cpu_lpm_seq.sv
module cpu_lpm_seq #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_wr,
  input  logic [1:0]       mode_wdata,
  input  logic [CNT_W-1:0] settle_cycles,
  input  logic             wfi,
  input  logic             irq_pending,
  input  logic             all_idle,
  input  logic             cache_stby_ack,
  input  logic             rm_ack,
  output logic             clk_gate,
  output logic             ret_req,
  output logic             pwr_en,
  output logic             core_rst,
  output logic             cache_stby_req,
  output logic             rm_req,
  output logic [3:0]       state_o,
  output logic [1:0]       mode_o,
  output logic [1:0]       last_mode,
  output logic             last_valid
);
  localparam logic [1:0] M_STBY = 2'd0, M_RET = 2'd1, M_SPC = 2'd2, M_PC = 2'd3;

  typedef enum logic [3:0] {
    S_IDLE = 4'd0, S_RET_DN = 4'd1, S_PWR_DN = 4'd2, S_WAIT = 4'd3, S_RM_REQ = 4'd4,
    S_RM_REL = 4'd5, S_RET_UP = 4'd6, S_PWR_UP = 4'd7, S_CCHK = 4'd8
  } st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       mode_q, mode_l;
  logic             wfi_q, hs_done, ret_q, pwr_q, rst_q, cache_q, rm_q;

  wire trig = wfi & ~wfi_q;
  wire cnt_zero = (cnt == '0);

  assign clk_gate       = (st != S_IDLE);
  assign ret_req        = ret_q;
  assign pwr_en         = pwr_q;
  assign core_rst       = rst_q;
  assign cache_stby_req = cache_q;
  assign rm_req         = rm_q;
  assign state_o        = st;
  assign mode_o         = mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; mode_q <= M_STBY; mode_l <= M_STBY;
      wfi_q <= 1'b0; hs_done <= 1'b0; ret_q <= 1'b0; pwr_q <= 1'b1;
      rst_q <= 1'b0; cache_q <= 1'b0; rm_q <= 1'b0;
      last_mode <= M_STBY; last_valid <= 1'b0;
    end else begin
      wfi_q <= wfi;
      case (st)
        S_IDLE: begin
          if (mode_wr) mode_q <= mode_wdata;
          if (trig && !irq_pending) begin
            mode_l  <= mode_q;
            hs_done <= 1'b0;
            case (mode_q)
              M_STBY:  st <= S_WAIT;
              M_RET:   begin ret_q <= 1'b1; cnt <= settle_cycles; st <= S_RET_DN; end
              default: begin pwr_q <= 1'b0; rst_q <= 1'b1; cnt <= settle_cycles; st <= S_PWR_DN; end
            endcase
          end
        end
        S_RET_DN, S_PWR_DN: begin
          if (cnt_zero) st <= S_WAIT;
          else cnt <= cnt - 1'b1;
        end
        S_WAIT: begin
          cache_q <= (mode_l == M_STBY) && all_idle && !irq_pending;
          if (irq_pending) begin
            case (mode_l)
              M_STBY: st <= S_CCHK;
              M_RET:  begin ret_q <= 1'b0; cnt <= settle_cycles; st <= S_RET_UP; end
              default: begin
                if (mode_l == M_PC && hs_done) st <= S_RM_REL;
                else begin pwr_q <= 1'b1; cnt <= settle_cycles; st <= S_PWR_UP; end
              end
            endcase
          end else if (mode_l == M_PC && all_idle && !hs_done) begin
            rm_q <= 1'b1;
            st   <= S_RM_REQ;
          end
        end
        S_RM_REQ: begin
          if (rm_ack) begin rm_q <= 1'b0; hs_done <= 1'b1; st <= S_WAIT; end
        end
        S_RM_REL: begin
          if (!rm_ack) begin pwr_q <= 1'b1; cnt <= settle_cycles; st <= S_PWR_UP; end
        end
        S_RET_UP, S_PWR_UP: begin
          if (cnt_zero) st <= S_CCHK;
          else cnt <= cnt - 1'b1;
        end
        S_CCHK: begin
          if (!cache_stby_ack) begin
            rst_q      <= 1'b0;
            mode_q     <= M_STBY;
            last_mode  <= mode_l;
            last_valid <= 1'b1;
            st         <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_off_gated_r7: assert property (@(posedge clk) disable iff (!rst_n) !pwr_en |-> clk_gate);
  p_ret_powered_r6: assert property (@(posedge clk) disable iff (!rst_n) ret_req |-> pwr_en);
  p_cache_idle_r5: assert property (@(posedge clk) disable iff (!rst_n) cache_stby_req |-> $past(all_idle));
  p_resume_cache_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(core_rst) || $fell(clk_gate)) |-> !$past(cache_stby_ack));
  p_rst_powered_r7: assert property (@(posedge clk) disable iff (!rst_n) $fell(core_rst) |-> pwr_en && $past(pwr_en));
  p_settle_after_up_r7: assert property (@(posedge clk) disable iff (!rst_n) $rose(pwr_en) |=> core_rst);
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n) (rm_req && !rm_ack) |=> rm_req);
  p_req_drop_r9: assert property (@(posedge clk) disable iff (!rst_n) $fell(rm_req) |-> $past(rm_ack));
  p_ack_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pwr_en) && mode_l == M_PC && hs_done) |-> !$past(rm_ack));
  p_spc_alone_r8: assert property (@(posedge clk) disable iff (!rst_n) (mode_l == M_SPC && clk_gate) |-> !rm_req);
  p_revert_r4: assert property (@(posedge clk) disable iff (!rst_n) $rose(last_valid) |-> mode_o == M_STBY);
endmodule

// File: tb/cpu_lpm_seq_tb.sv
module cpu_lpm_seq_tb_top;
  localparam int CNT_W = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_wr = 1'b0, wfi = 1'b0, irq_pending = 1'b0, all_idle = 1'b0;
  logic cache_stby_ack = 1'b0, rm_ack = 1'b0;
  logic [1:0] mode_wdata = 2'd0;
  logic [CNT_W-1:0] settle_cycles = '0;
  logic clk_gate, ret_req, pwr_en, core_rst, cache_stby_req, rm_req, last_valid;
  logic [3:0] state_o;
  logic [1:0] mode_o, last_mode;
  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cpu_lpm_seq #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .settle_cycles(settle_cycles), .wfi(wfi), .irq_pending(irq_pending),
    .all_idle(all_idle), .cache_stby_ack(cache_stby_ack), .rm_ack(rm_ack),
    .clk_gate(clk_gate), .ret_req(ret_req), .pwr_en(pwr_en), .core_rst(core_rst),
    .cache_stby_req(cache_stby_req), .rm_req(rm_req), .state_o(state_o),
    .mode_o(mode_o), .last_mode(last_mode), .last_valid(last_valid));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_mode(input int m);
    mode_wdata = 2'(m); mode_wr = 1'b1;
    step(1);
    mode_wr = 1'b0;
  endtask

  task automatic run_seq(input int m, input int s, input bit idle);
    int n;
    int exp_wait;
    all_idle = idle; settle_cycles = CNT_W'(s);
    write_mode(m);
    chk(mode_o == 2'(m), "R4 mode load", mode_o, m);
    wfi = 1'b1;
    n = 0;
    exp_wait = (m == 0) ? 1 : s + 2;
    for (int i = 0; i < 40; i++) begin
      step(1); n++;
      if (n == 1) begin
        chk(clk_gate == 1'b1, "R2 gate on trigger", clk_gate, 1);
        chk(ret_req == (m == 1), "R6 retention request", ret_req, m == 1);
        chk(pwr_en == (m < 2), "R7 power removed", pwr_en, m < 2);
        chk(core_rst == (m >= 2), "R7 reset held", core_rst, m >= 2);
      end
      if (state_o == 4'd3) break;
    end
    chk(n == exp_wait, "R7 entry settle length", n, exp_wait);
    write_mode(m ^ 1);
    chk(mode_o == 2'(m), "R4 write ignored while busy", mode_o, m);
    step(3);
    if (m == 3 && idle) begin
      chk(state_o == 4'd4 && rm_req, "R9 request raised", state_o, 4);
      step(2);
      chk(rm_req == 1'b1, "R9 request held", rm_req, 1);
      rm_ack = 1'b1;
      step(1);
      chk(rm_req == 1'b0 && state_o == 4'd3, "R9 request dropped on ack", rm_req, 0);
      irq_pending = 1'b1;
      step(3);
      chk(state_o == 4'd5 && !pwr_en, "R9 power held while ack high", state_o, 5);
      rm_ack = 1'b0;
      step(s + 6);
      chk(state_o == 4'd0 && !clk_gate, "R9 exit after ack low", state_o, 0);
    end else begin
      chk(state_o == 4'd3, "R10 stays waiting", state_o, 3);
      chk(rm_req == 1'b0, "R8 no request", rm_req, 0);
      if (m == 0) chk(cache_stby_req == idle, "R5 cache standby request", cache_stby_req, idle);
      irq_pending = 1'b1;
      n = 0;
      for (int i = 0; i < 40; i++) begin
        step(1); n++;
        if (n == 1 && m >= 2) chk(pwr_en == 1'b1, "R7 power restored at wake", pwr_en, 1);
        if (n == 1 && m == 1) chk(ret_req == 1'b0, "R6 retention dropped", ret_req, 0);
        if (n == 1) chk(cache_stby_req == 1'b0, "R5 cache request dropped", cache_stby_req, 0);
        if (!clk_gate) break;
      end
      chk(n == ((m == 0) ? 2 : s + 3), "R7 exit settle length", n, (m == 0) ? 2 : s + 3);
    end
    chk(core_rst == 1'b0 && pwr_en == 1'b1, "R7 core released", core_rst, 0);
    chk(last_valid && last_mode == 2'(m), "R4 last mode", last_mode, m);
    chk(mode_o == 2'd0, "R4 revert to standby", mode_o, 0);
    irq_pending = 1'b0; wfi = 1'b0; all_idle = 1'b0;
    step(2);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(3);
    chk(!clk_gate && !ret_req && !cache_stby_req && !rm_req && !core_rst && pwr_en,
        "R1 reset outputs", {clk_gate, ret_req, pwr_en, core_rst}, 2);
    chk(state_o == 0 && mode_o == 0 && !last_valid, "R1 reset state", state_o, 0);
    rst_n = 1'b1;
    step(2);
    for (int s = 0; s < 4; s++)
      for (int m = 0; m < 4; m++)
        for (int idle = 0; idle < 2; idle++)
          run_seq(m, s, idle[0]);
    // R3: pending interrupt at trigger skips the run
    write_mode(1);
    irq_pending = 1'b1; wfi = 1'b1;
    step(4);
    chk(!clk_gate && !ret_req && pwr_en && state_o == 0, "R3 skip no gating", state_o, 0);
    chk(mode_o == 2'd1, "R3 mode kept", mode_o, 1);
    irq_pending = 1'b0; wfi = 1'b0;
    step(2);
    // R5: cache still in standby holds the core
    write_mode(0);
    all_idle = 1'b1; wfi = 1'b1;
    step(3);
    cache_stby_ack = 1'b1; irq_pending = 1'b1;
    step(4);
    chk(state_o == 4'd8 && clk_gate, "R5 hold while cache in standby", state_o, 8);
    cache_stby_ack = 1'b0;
    step(2);
    chk(state_o == 4'd0 && !clk_gate, "R5 resume after cache exit", state_o, 0);
    irq_pending = 1'b0; wfi = 1'b0;
    step(2);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule